// File: doc/BRIEF.md
# Cascaded Two-Stage Time-Base Prescaler

This block turns a slow reference clock, presented as a clock enable, into a periodic one-cycle tick that paces a real-time counter, for example one pulse per second. Software writes a 20-bit load value. The block does not treat it as one 20-bit count. It splits the value into a 16-bit low divider and a 4-bit high divider that run in cascade. The low divider counts enabled clocks. Each time the low divider runs out, the high divider takes one step. The tick period is therefore the product (high + 1) × (low + 1), not the load value plus one.

Counting is steered by a per-cycle step decode with five named steps:
- STEP_IDLE: no enable, so the counters hold.
- STEP_LOW: the low divider decrements.
- STEP_CARRY: the low divider is at zero. It reloads, and the high divider decrements.
- STEP_WRAP: both dividers are at zero. Both reload from the programmed value, and a tick is emitted.
- STEP_RESTART: a synchronous restart reloads both dividers and drops any tick.

The transitions are:
- STEP_RESTART always wins.
- Otherwise a cycle with no enable is STEP_IDLE.
- An enabled cycle becomes STEP_WRAP, STEP_CARRY or STEP_LOW from the zero flags of the two dividers, checked in that order.

A write changes only the programmed value. Running counters pick it up at the next STEP_WRAP or STEP_RESTART. Between those points, low-stage reloads keep using the value captured at the last full reload. The remaining count can be read back at any time, packed in the same bit positions as the load value.

Top module: `rtc_cascade_prescaler`

## Requirements
- R1: Load bits [15:0] are the low-stage reload and bits [19:16] the high-stage reload; `remain` packs the high counter in [19:16] and the low counter in [15:0].
- R2: After a reload to (H, L), the next tick results from the (H+1)×(L+1)-th enabled clock edge.
- R3: `tick` is high for exactly the one clock cycle that follows the enabled edge on which both counters were zero.
- R4: On an enabled edge with the low counter non-zero, the low counter decrements by one and the high counter holds.
- R5: On an enabled edge with the low counter zero and the high counter non-zero, the high counter decrements and the low counter reloads from the low field captured at the last full reload.
- R6: A write to the load value does not change `remain` on that edge and takes effect only at the next full reload (wrap or restart).
- R7: `restart` has priority over `ce`; it loads both counters from the programmed load value and forces `tick` low on the following cycle.
- R8: With `ce` low and no restart, `remain` holds and `tick` is low.
- R9: A load value of 0 makes a tick follow every enabled edge.
- R10: Asynchronous reset sets the programmed value and both counters to RESET_LOAD (default 20'h07FFF) and `tick` low.
- R11: With load 227857 (H=3, L=31249) or 128035 (H=1, L=62499), one tick period spans 125000 enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | One-cycle enable from the slow reference clock |
| restart | input | 1 | Synchronous restart of both dividers from the programmed value |
| wr_en | input | 1 | Write strobe for the load value |
| wr_data | input | 20 | Load value: [19:16] high stage, [15:0] low stage |
| remain | output | 20 | Remaining count: [19:16] high counter, [15:0] low counter |
| tick | output | 1 | One-cycle time-base pulse |

## Verification
The cascade is driven with several load patterns.
- A small product (2,4) with a continuous enable, and a (1,2) product with a gapped enable, separate an edge-counting divider from a cycle-counting one.
- A load of zero exposes an off-by-one in the wrap decode.
- The two 125000-clock load values separate the product rule from a plain 20-bit count. The first is run over a full period. The second is checked through its mid-period readback.

Three further cases isolate the reload sources:
- A write in the middle of a period, followed by a carry, shows whether low-stage reloads wrongly use the freshly written value.
- A restart that lands on a wrap edge shows whether restart outranks the tick.
- Idle stretches with no enable catch counters that move without it.

// File: rtl/rtcpre_pkg.sv
package rtcpre_pkg;

    // Per-cycle step taken by the cascade
    typedef enum logic [2:0] {
        STEP_IDLE    = 3'd0,
        STEP_LOW     = 3'd1,
        STEP_CARRY   = 3'd2,
        STEP_WRAP    = 3'd3,
        STEP_RESTART = 3'd4
    } step_e;

endpackage

// File: rtl/rtcpre_stage.sv
module rtcpre_stage #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         is_zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= RST_VAL;
        end else if (load_en) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - W'(1);
        end
    end

    assign is_zero = (cnt == '0);

endmodule

// File: rtl/rtcpre_loadreg.sv
module rtcpre_loadreg #(
    parameter int              LW        = 20,
    parameter logic [LW-1:0]   RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_data,
    input  logic          capture,
    output logic [LW-1:0] prog_q,
    output logic [LW-1:0] act_q
);

    // Programmed value, written by software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q <= RESET_VAL;
        end else if (wr_en) begin
            prog_q <= wr_data;
        end
    end

    // Active value, captured only at a full reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= RESET_VAL;
        end else if (capture) begin
            act_q <= prog_q;
        end
    end

endmodule

// File: rtl/rtcpre_ctrl.sv
module rtcpre_ctrl
    import rtcpre_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ce,
    input  logic  restart,
    input  logic  low_zero,
    input  logic  high_zero,
    output step_e step,
    output logic  tick
);

    // Step decode: restart first, then enable, then the zero flags
    always_comb begin
        if (restart) begin
            step = STEP_RESTART;
        end else if (!ce) begin
            step = STEP_IDLE;
        end else if (low_zero && high_zero) begin
            step = STEP_WRAP;
        end else if (low_zero) begin
            step = STEP_CARRY;
        end else begin
            step = STEP_LOW;
        end
    end

    // Output register: one-cycle tick after a wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            unique case (step)
                STEP_WRAP:    tick <= 1'b1;
                STEP_RESTART: tick <= 1'b0;
                STEP_IDLE,
                STEP_LOW,
                STEP_CARRY:   tick <= 1'b0;
                default:      tick <= 1'b0;
            endcase
        end
    end

    // R7: a restart always leaves tick low next cycle
    a_r7_restart_kills_tick: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

    // R8: no enable, no tick
    a_r8_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !restart) |=> !tick);

endmodule

// File: rtl/rtc_cascade_prescaler.sv
module rtc_cascade_prescaler
    import rtcpre_pkg::*;
#(
    parameter int LOW_W  = 16,
    parameter int HIGH_W = 4,
    parameter logic [LOW_W+HIGH_W-1:0] RESET_LOAD = (LOW_W+HIGH_W)'(32767)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce,
    input  logic                      restart,
    input  logic                      wr_en,
    input  logic [LOW_W+HIGH_W-1:0]   wr_data,
    output logic [LOW_W+HIGH_W-1:0]   remain,
    output logic                      tick
);

    localparam int LOAD_W = LOW_W + HIGH_W;

    logic [LOAD_W-1:0] prog_q;
    logic [LOAD_W-1:0] act_q;
    logic [LOW_W-1:0]  low_cnt;
    logic [HIGH_W-1:0] high_cnt;
    logic              low_zero;
    logic              high_zero;
    step_e             step;

    logic              capture;
    logic              low_load;
    logic              low_dec;
    logic [LOW_W-1:0]  low_src;
    logic              high_load;
    logic              high_dec;

    rtcpre_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .restart   (restart),
        .low_zero  (low_zero),
        .high_zero (high_zero),
        .step      (step),
        .tick      (tick)
    );

    rtcpre_loadreg #(
        .LW        (LOAD_W),
        .RESET_VAL (RESET_LOAD)
    ) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .capture (capture),
        .prog_q  (prog_q),
        .act_q   (act_q)
    );

    // Stage actions per step
    always_comb begin
        capture   = 1'b0;
        low_load  = 1'b0;
        low_dec   = 1'b0;
        low_src   = prog_q[LOW_W-1:0];
        high_load = 1'b0;
        high_dec  = 1'b0;
        unique case (step)
            STEP_RESTART,
            STEP_WRAP: begin
                capture   = 1'b1;
                low_load  = 1'b1;
                high_load = 1'b1;
            end
            STEP_CARRY: begin
                low_load = 1'b1;
                low_src  = act_q[LOW_W-1:0];
                high_dec = 1'b1;
            end
            STEP_LOW: begin
                low_dec = 1'b1;
            end
            STEP_IDLE: begin
            end
            default: begin
            end
        endcase
    end

    rtcpre_stage #(
        .W       (LOW_W),
        .RST_VAL (RESET_LOAD[LOW_W-1:0])
    ) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (low_load),
        .load_val (low_src),
        .dec      (low_dec),
        .cnt      (low_cnt),
        .is_zero  (low_zero)
    );

    rtcpre_stage #(
        .W       (HIGH_W),
        .RST_VAL (RESET_LOAD[LOAD_W-1:LOW_W])
    ) u_high (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (high_load),
        .load_val (prog_q[LOAD_W-1:LOW_W]),
        .dec      (high_dec),
        .cnt      (high_cnt),
        .is_zero  (high_zero)
    );

    assign remain = {high_cnt, low_cnt};

    // R4: low stage steps by one, high stage holds
    a_r4_low_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !restart && remain[LOW_W-1:0] != '0)
        |=> (remain[LOW_W-1:0] == $past(remain[LOW_W-1:0]) - LOW_W'(1))
            && (remain[LOAD_W-1:LOW_W] == $past(remain[LOAD_W-1:LOW_W])));

    // R5: carry reloads low from the active value, high steps down
    a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !restart && remain[LOW_W-1:0] == '0 && remain[LOAD_W-1:LOW_W] != '0)
        |=> (remain[LOW_W-1:0] == $past(act_q[LOW_W-1:0]))
            && (remain[LOAD_W-1:LOW_W] == $past(remain[LOAD_W-1:LOW_W]) - HIGH_W'(1)));

    // R3: both zero on an enabled edge gives a tick and a full reload
    a_r3_wrap_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !restart && remain == '0) |=> tick && (remain == $past(prog_q)));

    // R7: restart reloads from the programmed value
    a_r7_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> remain == $past(prog_q));

    // R8 / R6: no enable, no restart: counts hold even across a write
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !restart) |=> $stable(remain));

endmodule

// File: tb/rtc_cascade_prescaler_tb.sv
module rtc_cascade_prescaler_tb;

    logic        clk;
    logic        rst_n;
    logic        ce;
    logic        restart;
    logic        wr_en;
    logic [19:0] wr_data;
    logic [19:0] remain;
    logic        tick;

    int errors;
    int checks;
    int unsigned ce_cnt;
    int unsigned exp_q[$];
    bit done;

    rtc_cascade_prescaler u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .restart (restart),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .remain  (remain),
        .tick    (tick)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Count enabled edges that are not overridden by restart
    always @(posedge clk) begin
        if (rst_n && ce && !restart) ce_cnt <= ce_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: every tick must match the next scheduled edge count
    always @(negedge clk) begin
        if (rst_n && tick && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected tick at edge", ce_cnt, 0);
            end else begin
                int unsigned e;
                e = exp_q.pop_front();
                chk(ce_cnt == e, "R2 tick edge count", ce_cnt, e);
            end
        end
    end

    task automatic write_load(input logic [19:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Restart with ce high (restart must win); returns base edge count
    task automatic do_restart(input logic [19:0] exp_load, output int unsigned base);
        restart = 1'b1;
        ce      = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        ce      = 1'b0;
        base    = ce_cnt;
        chk(remain == exp_load, "R7 restart reload / R1 packing", remain, exp_load);
        chk(tick == 1'b0, "R7 tick low after restart", tick, 0);
    endtask

    task automatic push_ticks(input int unsigned base, input int unsigned per,
                              input int n);
        for (int k = 1; k <= n; k++) exp_q.push_back(base + per * k);
    endtask

    task automatic run_ce(input int n, input bit gapped);
        int d;
        int c;
        d = 0;
        c = 0;
        while (d < n) begin
            if (gapped && (c % 3 == 0)) begin
                ce = 1'b0;
            end else begin
                ce = 1'b1;
                d++;
            end
            c++;
            @(negedge clk);
        end
        ce = 1'b0;
    endtask

    initial begin
        int unsigned base;
        logic [19:0] snap;
        errors  = 0;
        checks  = 0;
        ce_cnt  = 0;
        done    = 0;
        rst_n   = 1'b0;
        ce      = 1'b0;
        restart = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(remain == 20'h07FFF, "R10 reset remain", remain, 20'h07FFF);
        chk(tick == 1'b0, "R10 reset tick", tick, 0);

        // R1 packing on readback
        write_load(20'hA1234);
        do_restart(20'hA1234, base);

        // R2/R3 product period, continuous enable: H=2 L=4 -> 15
        write_load(20'h20004);
        do_restart(20'h20004, base);
        push_ticks(base, 15, 3);
        run_ce(45, 1'b0);

        // R2 gapped enable: H=1 L=2 -> 6
        write_load(20'h10002);
        do_restart(20'h10002, base);
        push_ticks(base, 6, 4);
        run_ce(24, 1'b1);

        // R8 idle hold
        run_ce(4, 1'b0);
        snap = remain;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(remain == snap, "R8 hold without ce", remain, snap);
        end

        // R9 load of zero: tick after each enabled edge
        write_load(20'h00000);
        do_restart(20'h00000, base);
        push_ticks(base, 1, 6);
        run_ce(6, 1'b0);

        // R6/R5 mid-period write: H=1 L=3 (period 8), then write 1 (period 2)
        write_load(20'h10003);
        do_restart(20'h10003, base);
        push_ticks(base, 8, 1);
        push_ticks(base + 8, 2, 2);
        run_ce(2, 1'b0);
        chk(remain == 20'h10001, "R4 low step before write", remain, 20'h10001);
        write_load(20'h00001);
        chk(remain == 20'h10001, "R6 write leaves remain", remain, 20'h10001);
        run_ce(2, 1'b0);
        chk(remain == 20'h00003, "R5 carry uses active low field", remain, 20'h00003);
        run_ce(8, 1'b0);

        // R7 restart on a wrap edge: load 5, 5 edges, then restart with ce
        write_load(20'h00005);
        do_restart(20'h00005, base);
        run_ce(5, 1'b0);
        chk(remain == 20'h00000, "R4 reached zero", remain, 0);
        do_restart(20'h00005, base);
        push_ticks(base, 6, 1);
        run_ce(6, 1'b0);

        // R11 load 227857: one tick per 125000 edges
        write_load(20'd227857);
        do_restart(20'd227857, base);
        push_ticks(base, 125000, 1);
        run_ce(31250, 1'b0);
        chk(remain == 20'h27A11, "R11 227857 carry readback", remain, 20'h27A11);
        run_ce(93750, 1'b0);
        chk(remain == 20'd227857, "R11 227857 reload after tick", remain, 20'd227857);

        // R11 load 128035: half period (62500 edges) reaches H=0 L=62499
        write_load(20'd128035);
        do_restart(20'd128035, base);
        run_ce(62500, 1'b0);
        chk(remain == 20'h0F423, "R11 128035 half-period readback", remain, 20'h0F423);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all scheduled ticks seen", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule